// File: doc/BRIEF.md
# Parcel Fetch and Instruction Buffer

This block is the front end of a CPU whose instructions are built from 16-bit parcels. It keeps a parcel-granular program counter. The counter's two low bits pick one of four parcels in a 64-bit memory word, and its upper bits give the word address. The block looks that address up in four small instruction buffers, which are fully associative and each tagged with an aligned block address. On a hit, the addressed parcel moves into a next-parcel register. From there it goes to the current-parcel register, which holds the instruction waiting to issue. A second parcel register backs up two-parcel instructions.

On a miss, the block raises a fill request for the aligned block and names a victim buffer taken in strict round-robin order. An external fill engine then writes the block one word per cycle. A taken branch reloads the program counter and flushes the parcel pipeline, but it keeps the buffers, so branching into code that is already held costs no memory traffic. A context exchange also reloads the counter, and in addition it voids every buffer. Issue can be held by the execution side, and the current parcel then stays put.

Top module: `pfb_fetch`

## Requirements
- R1: Program addresses are parcel addresses. Bits [1:0] select the parcel within a 64-bit word, and parcel 0 occupies word bits [63:48]. The fill address is the word address (program address bits [23:2]) with its low log2(WPB) bits forced to zero.
- R2: After a redirect to address A, the issued parcels are those at A, A+1, A+2 and so on in order. The program counter advances by exactly one for each parcel loaded into the next-parcel register.
- R3: When `two_parcel` is high, the block issues only once `lip` holds the parcel that follows the one in `cip`.
- R4: Each miss picks victim buffer `fill_slot` from a 2-bit counter. The counter is 0 after reset and advances by one, modulo 4, per miss.
- R5: `xchg_go` loads the program counter, empties the parcel registers and invalidates all buffers. A later access to a block that was held before the exchange therefore requests a fill.
- R6: A branch, forward or backward, to an address inside a valid buffer raises no fill request. At most one buffer matches any address.
- R7: While `hold_issue` is high, `issue_go` stays low, and a valid `cip` keeps both its value and its valid flag.
- R8: After reset, `cip_vld`, `issue_go` and `fill_req` are low, the program counter is 0 and the victim counter is 0.
- R9: `fill_req` stays high until the word with index WPB-1 has been written. No parcel of the block being filled is used before that write.
- R10: A branch (`br_take`) discards any parcels already fetched, and no instruction issues in the redirect cycle. When `br_take` and `xchg_go` are high together, the exchange target wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_take | input | 1 | Taken branch, loads `br_target` |
| br_target | input | 24 | Branch parcel address |
| xchg_go | input | 1 | Context exchange, loads `xchg_target`, voids buffers |
| xchg_target | input | 24 | Program address of incoming context |
| hold_issue | input | 1 | Blocks issue of the current parcel |
| two_parcel | input | 1 | Decode says the instruction in `cip` is two parcels long |
| fill_req | output | 1 | A block fill is wanted |
| fill_addr | output | 22 | Aligned word address of the block to fill |
| fill_slot | output | log2(NBUF) | Victim buffer receiving the fill |
| fill_we | input | 1 | Fill word strobe |
| fill_widx | input | log2(WPB) | Word index inside the block |
| fill_word | input | 64 | Fill data |
| pc | output | 24 | Program counter (next parcel to fetch) |
| cip | output | 16 | Current parcel (instruction waiting to issue) |
| lip | output | 16 | Second parcel of a two-parcel instruction |
| cip_vld | output | 1 | `cip` holds a valid parcel |
| issue_go | output | 1 | The instruction in `cip` issues at this edge |

## Verification
The bench walks a branch table whose targets hit, miss and cross block boundaries. This catches a victim counter that skips or restarts, because the slot sequence drifts from 0,1,2,3,0. It also catches a block that refills on a backward branch, because an extra fill request appears. A design that loads the wrong parcel half or misaligns the fill address shows up as a wrong issued value. Three directed cases follow. Issuing two-parcel instructions exposes a design that issues before the second parcel is in place. An exchange back into a block that had been buffered exposes buffers that survive the exchange. Stalling the fill engine shows whether the block uses a partly filled buffer or drops its request early.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
  localparam int PA_W     = 24;
  localparam int PARCEL_W = 16;
  localparam int PPW      = 4;
  localparam int PIDX_W   = 2;
  localparam int WORD_W   = PARCEL_W * PPW;
  localparam int WA_W     = PA_W - PIDX_W;

  typedef logic [PARCEL_W-1:0] parcel_t;
  typedef logic [WORD_W-1:0]   word_t;
  typedef logic [PA_W-1:0]     pa_t;
  typedef logic [WA_W-1:0]     wa_t;

  function automatic wa_t word_addr(pa_t a);
    return a[PA_W-1:PIDX_W];
  endfunction

  function automatic logic [PIDX_W-1:0] parcel_idx(pa_t a);
    return a[PIDX_W-1:0];
  endfunction

  // parcel 0 is the most significant quarter of the word
  function automatic parcel_t pick_parcel(word_t w, logic [PIDX_W-1:0] i);
    return w[WORD_W-1-PARCEL_W*int'(i) -: PARCEL_W];
  endfunction
endpackage

// File: rtl/pfb_buf_bank.sv
module pfb_buf_bank
  import pfb_pkg::*;
#(
  parameter int NBUF = 4,
  parameter int WPB  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              open_en,
  input  logic [$clog2(NBUF)-1:0] open_idx,
  input  logic [WA_W-$clog2(WPB)-1:0] open_tag,
  input  logic              close_en,
  input  logic [$clog2(NBUF)-1:0] close_idx,
  input  logic              wr_en,
  input  logic [$clog2(NBUF)-1:0] wr_buf,
  input  logic [$clog2(WPB)-1:0]  wr_widx,
  input  word_t             wr_word,
  input  wa_t               look_wa,
  output logic              hit,
  output word_t             hit_word,
  output logic              any_vld
);
  localparam int WI_W  = $clog2(WPB);
  localparam int TAG_W = WA_W - WI_W;

  word_t             mem   [NBUF][WPB];
  logic [TAG_W-1:0]  tag_q [NBUF];
  logic [NBUF-1:0]   vld_q;
  logic [NBUF-1:0]   hit_vec;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_buf][wr_widx] <= wr_word;
    if (open_en) tag_q[open_idx] <= open_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_all) vld_q <= '0;
    else begin
      if (open_en)  vld_q[open_idx]  <= 1'b0;
      if (close_en) vld_q[close_idx] <= 1'b1;
    end
  end

  for (genvar b = 0; b < NBUF; b++) begin : g_cmp
    assign hit_vec[b] = vld_q[b] && (tag_q[b] == look_wa[WA_W-1:WI_W]);
  end

  always_comb begin
    hit_word = '0;
    for (int b = 0; b < NBUF; b++)
      hit_word |= mem[b][look_wa[WI_W-1:0]] & {WORD_W{hit_vec[b]}};
  end

  assign hit     = |hit_vec;
  assign any_vld = |vld_q;

  // R6
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/pfb_fill_ctrl.sv
module pfb_fill_ctrl
  import pfb_pkg::*;
#(
  parameter int NBUF = 4,
  parameter int WPB  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss,
  input  logic              abort,
  input  wa_t               look_wa,
  input  logic              wr_en,
  input  logic [$clog2(WPB)-1:0] wr_widx,
  output logic              busy,
  output wa_t               base_wa,
  output logic [$clog2(NBUF)-1:0] slot,
  output logic              start,
  output logic [WA_W-$clog2(WPB)-1:0] start_tag,
  output logic              accept,
  output logic              done
);
  localparam int NB_W = $clog2(NBUF);
  localparam int WI_W = $clog2(WPB);
  localparam logic [WI_W-1:0] LAST = WI_W'(WPB - 1);

  logic [NB_W-1:0] rr_q;
  logic            busy_q;
  wa_t             base_q;
  logic [NB_W-1:0] slot_q;

  function automatic wa_t align_block(wa_t w);
    return {w[WA_W-1:WI_W], {WI_W{1'b0}}};
  endfunction

  assign start     = miss && !busy_q && !abort;
  assign start_tag = look_wa[WA_W-1:WI_W];
  assign accept    = busy_q && wr_en && !abort;
  assign done      = accept && (wr_widx == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q   <= '0;
      busy_q <= 1'b0;
      slot_q <= '0;
      base_q <= '0;
    end else if (abort) begin
      busy_q <= 1'b0;
    end else if (start) begin
      rr_q   <= rr_q + 1'b1;
      slot_q <= rr_q;
      base_q <= align_block(look_wa);
      busy_q <= 1'b1;
    end else if (done) begin
      busy_q <= 1'b0;
    end
  end

  assign busy    = busy_q;
  assign base_wa = base_q;
  assign slot    = start ? rr_q : slot_q;

  // R4
  rr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> rr_q == $past(rr_q) + 1'b1);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !abort && !(wr_en && wr_widx == LAST) |=> busy_q);
endmodule

// File: rtl/pfb_fetch.sv
module pfb_fetch
  import pfb_pkg::*;
#(
  parameter int NBUF = 4,
  parameter int WPB  = 4,
  localparam int NB_W = $clog2(NBUF),
  localparam int WI_W = $clog2(WPB)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 br_take,
  input  logic [PA_W-1:0]      br_target,
  input  logic                 xchg_go,
  input  logic [PA_W-1:0]      xchg_target,
  input  logic                 hold_issue,
  input  logic                 two_parcel,
  output logic                 fill_req,
  output logic [WA_W-1:0]      fill_addr,
  output logic [NB_W-1:0]      fill_slot,
  input  logic                 fill_we,
  input  logic [WI_W-1:0]      fill_widx,
  input  logic [WORD_W-1:0]    fill_word,
  output logic [PA_W-1:0]      pc,
  output logic [PARCEL_W-1:0]  cip,
  output logic [PARCEL_W-1:0]  lip,
  output logic                 cip_vld,
  output logic                 issue_go
);
  pa_t     pc_q;
  parcel_t nip_q, cip_q, lip_q;
  logic    nip_v, cip_v, lip_v;

  logic    hit, any_vld, redirect, fetch, miss;
  logic    cip_free, nip_to_cip, nip_to_lip, nip_free;
  word_t   hit_word;
  pa_t     new_pc;
  logic    f_start, f_accept, f_done, f_busy;
  logic [WA_W-WI_W-1:0] f_tag;
  logic [NB_W-1:0] f_slot;
  wa_t     f_base;

  assign redirect   = br_take || xchg_go;
  assign new_pc     = xchg_go ? xchg_target : br_target;
  assign issue_go   = cip_v && !hold_issue && (!two_parcel || lip_v) && !redirect;
  assign cip_free   = !cip_v || issue_go;
  assign nip_to_cip = nip_v && cip_free && !redirect;
  assign nip_to_lip = nip_v && cip_v && two_parcel && !lip_v && !redirect;
  assign nip_free   = !nip_v || nip_to_cip || nip_to_lip;
  assign fetch      = hit && nip_free && !redirect;
  assign miss       = !hit && !redirect;

  pfb_buf_bank #(.NBUF(NBUF), .WPB(WPB)) u_bank (
    .clk(clk), .rst_n(rst_n), .clr_all(xchg_go),
    .open_en(f_start), .open_idx(f_slot), .open_tag(f_tag),
    .close_en(f_done), .close_idx(f_slot),
    .wr_en(f_accept), .wr_buf(f_slot), .wr_widx(fill_widx), .wr_word(fill_word),
    .look_wa(word_addr(pc_q)), .hit(hit), .hit_word(hit_word), .any_vld(any_vld)
  );

  pfb_fill_ctrl #(.NBUF(NBUF), .WPB(WPB)) u_fill (
    .clk(clk), .rst_n(rst_n), .miss(miss), .abort(xchg_go),
    .look_wa(word_addr(pc_q)), .wr_en(fill_we), .wr_widx(fill_widx),
    .busy(f_busy), .base_wa(f_base), .slot(f_slot), .start(f_start),
    .start_tag(f_tag), .accept(f_accept), .done(f_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      nip_v <= 1'b0;
      cip_v <= 1'b0;
      lip_v <= 1'b0;
    end else if (redirect) begin
      pc_q  <= new_pc;
      nip_v <= 1'b0;
      cip_v <= 1'b0;
      lip_v <= 1'b0;
    end else begin
      if (fetch) begin
        pc_q  <= pc_q + 1'b1;
        nip_v <= 1'b1;
      end else if (nip_to_cip || nip_to_lip) begin
        nip_v <= 1'b0;
      end
      if (nip_to_cip)    cip_v <= 1'b1;
      else if (issue_go) cip_v <= 1'b0;
      if (nip_to_lip)    lip_v <= 1'b1;
      else if (issue_go) lip_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (fetch)      nip_q <= pick_parcel(hit_word, parcel_idx(pc_q));
    if (nip_to_cip) cip_q <= nip_q;
    if (nip_to_lip) lip_q <= nip_q;
  end

  assign fill_req  = f_busy;
  assign fill_addr = f_base;
  assign fill_slot = f_slot;
  assign pc        = pc_q;
  assign cip       = cip_q;
  assign lip       = lip_q;
  assign cip_vld   = cip_v;

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |=> pc_q == $past(pc_q) + 1'b1);
  // R7
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cip_v && hold_issue && !redirect |=> cip_v && $stable(cip_q));
  // R5
  xchg_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_go |=> !any_vld && !cip_v && !nip_v);
  // R10
  br_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_take && !xchg_go |=> pc_q == $past(br_target) && !cip_v);
endmodule

// File: tb/pfb_fetch_bench.sv
`timescale 1ns/1ps
module pfb_fetch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_take = 1'b0, xchg_go = 1'b0, hold_issue = 1'b1, two_parcel = 1'b0;
  logic [23:0] br_target = '0, xchg_target = '0;
  logic        fill_req, fill_we = 1'b0, cip_vld, issue_go;
  logic [21:0] fill_addr;
  logic [1:0]  fill_slot, fill_widx = '0;
  logic [63:0] fill_word = '0;
  logic [23:0] pc;
  logic [15:0] cip, lip;

  int total = 0, bad = 0;
  int iss_cnt = 0, vec_fills = 0;
  logic [23:0] exp_pa = '0;
  logic [21:0] first_fill = '0;
  logic [1:0]  rr_exp = '0;
  logic        req_prev = 1'b0, eng_on = 1'b1;

  always #2 clk = ~clk;

  pfb_fetch u_pfb_fetch (
    .clk(clk), .rst_n(rst_n), .br_take(br_take), .br_target(br_target),
    .xchg_go(xchg_go), .xchg_target(xchg_target), .hold_issue(hold_issue),
    .two_parcel(two_parcel), .fill_req(fill_req), .fill_addr(fill_addr),
    .fill_slot(fill_slot), .fill_we(fill_we), .fill_widx(fill_widx),
    .fill_word(fill_word), .pc(pc), .cip(cip), .lip(lip), .cip_vld(cip_vld),
    .issue_go(issue_go)
  );

  // memory image: parcel value as a function of its parcel address
  function automatic logic [15:0] par(logic [23:0] a);
    return {a[11:0], a[15:12]} ^ 16'h5A3C;
  endfunction
  function automatic logic [63:0] mkword(logic [21:0] wa);
    return {par({wa, 2'd0}), par({wa, 2'd1}), par({wa, 2'd2}), par({wa, 2'd3})};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // fill engine model: one word per cycle
  initial forever begin
    @(negedge clk);
    if (fill_req && eng_on && rst_n) begin
      logic [21:0] base;
      base = fill_addr;
      for (int i = 0; i < 4; i++) begin
        fill_we = 1'b1; fill_widx = 2'(i); fill_word = mkword(base + 22'(i));
        @(negedge clk);
      end
      fill_we = 1'b0;
    end
  end

  // monitor
  initial forever begin
    @(negedge clk); #1;
    if (rst_n) begin
      if (fill_req && !req_prev) begin
        chk(fill_slot == rr_exp, "R4 victim slot", 32'(fill_slot), 32'(rr_exp));
        rr_exp++;
        if (vec_fills == 0) first_fill = fill_addr;
        vec_fills++;
      end
      req_prev = fill_req;
      if (issue_go) begin
        chk(cip == par(exp_pa), "R2 issued parcel", 32'(cip), 32'(par(exp_pa)));
        if (two_parcel) begin
          chk(lip == par(exp_pa + 24'd1), "R3 second parcel", 32'(lip), 32'(par(exp_pa + 24'd1)));
          exp_pa += 24'd2;
        end else exp_pa += 24'd1;
        iss_cnt++;
      end
    end
  end

  // watchdog
  initial begin
    repeat (60000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic redirect_to(input logic [23:0] t, input logic xchg);
    @(negedge clk);
    if (xchg) begin xchg_go = 1'b1; xchg_target = t; end
    else begin br_take = 1'b1; br_target = t; end
    exp_pa = t; iss_cnt = 0; vec_fills = 0;
    @(negedge clk);
    br_take = 1'b0; xchg_go = 1'b0;
  endtask

  task automatic run_issues(input int n);
    int g = 0;
    hold_issue = 1'b0;
    while (iss_cnt < n && g < 500) begin @(posedge clk); g++; end
    @(negedge clk);
    hold_issue = 1'b1;
    chk(iss_cnt == n, "R2 issue count", 32'(iss_cnt), 32'(n));
  endtask

  // target, issues, expected fills
  localparam logic [39:0] VEC [0:9] = '{
    {24'h000100, 8'd6, 8'd1}, {24'h000450, 8'd5, 8'd1}, {24'h0007F2, 8'd7, 8'd1},
    {24'h001000, 8'd4, 8'd1}, {24'h000104, 8'd3, 8'd0}, {24'h000455, 8'd4, 8'd0},
    {24'h002000, 8'd5, 8'd1}, {24'h000105, 8'd3, 8'd1}, {24'h00080C, 8'd8, 8'd2},
    {24'h0007F4, 8'd3, 8'd1}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R8 reset state
    chk(!cip_vld, "R8 cip_vld", 32'(cip_vld), 0);
    chk(!fill_req, "R8 fill_req", 32'(fill_req), 0);
    chk(!issue_go, "R8 issue_go", 32'(issue_go), 0);
    chk(pc == 24'd0, "R8 pc", 32'(pc), 0);
    repeat (20) @(negedge clk);
    // boot fill of block 0 used slot 0 (checked by monitor), held cip = parcel 0
    chk(cip_vld && cip == par(24'd0), "R7 held boot parcel", 32'(cip), 32'(par(24'd0)));

    for (int v = 0; v < 10; v++) begin
      logic [23:0] t;
      int n, f;
      t = VEC[v][39:16]; n = int'(VEC[v][15:8]); f = int'(VEC[v][7:0]);
      redirect_to(t, 1'b0);
      run_issues(n);
      repeat (4) @(negedge clk);
      #2;
      chk(vec_fills == f, f == 0 ? "R6 no reload on buffered branch" : "R1 fills per run",
          32'(vec_fills), 32'(f));
      chk(cip_vld && cip == par(t + 24'(n)), "R7 cip kept under hold",
          32'(cip), 32'(par(t + 24'(n))));
      if (f > 0)
        chk(first_fill == ((t[23:2]) & ~22'd3), "R1 fill address", 32'(first_fill),
            32'((t[23:2]) & ~22'd3));
      chk(!fill_req, "R9 request dropped after last word", 32'(fill_req), 0);
    end

    // R3 two-parcel instructions in a buffered block
    @(negedge clk); two_parcel = 1'b1;
    redirect_to(24'h000100, 1'b0);
    run_issues(3);
    repeat (3) @(negedge clk);
    #2;
    chk(vec_fills == 0, "R3 no fill for buffered pairs", 32'(vec_fills), 0);
    @(negedge clk); two_parcel = 1'b0;

    // R5 exchange voids buffers: 0x800 block was held
    redirect_to(24'h000801, 1'b1);
    #1;
    chk(!cip_vld, "R5 cip emptied by exchange", 32'(cip_vld), 0);
    run_issues(4);
    repeat (3) @(negedge clk);
    #2;
    chk(vec_fills == 1, "R5 refill after exchange", 32'(vec_fills), 1);

    // R10 branch and exchange together: exchange target wins
    @(negedge clk);
    br_take = 1'b1; br_target = 24'h000100; xchg_go = 1'b1; xchg_target = 24'h000806;
    exp_pa = 24'h000806; iss_cnt = 0; vec_fills = 0;
    #1;
    chk(!issue_go, "R10 no issue on redirect", 32'(issue_go), 0);
    @(negedge clk); br_take = 1'b0; xchg_go = 1'b0;
    #1;
    chk(pc == 24'h000806, "R10 exchange priority", 32'(pc), 32'h806);
    run_issues(2);
    repeat (3) @(negedge clk);

    // R9 stalled fill engine
    @(negedge clk); eng_on = 1'b0;
    redirect_to(24'h003002, 1'b0);
    hold_issue = 1'b0;
    repeat (12) @(negedge clk);
    #2;
    chk(iss_cnt == 0, "R9 no issue from partial buffer", 32'(iss_cnt), 0);
    chk(fill_req == 1'b1, "R9 request held", 32'(fill_req), 1);
    @(negedge clk); eng_on = 1'b1;
    run_issues(3);
    repeat (3) @(negedge clk);
    #2;
    chk(vec_fills == 1, "R9 single fill", 32'(vec_fills), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule